// File: doc/BRIEF.md
# Sign-Magnitude Decimal Adder/Subtracter

This block adds or subtracts two signed decimal numbers held in sign-magnitude form, entirely in combinational logic. Each operand carries a sign bit (1 = negative) and a magnitude of `NDIG` packed BCD digits. A mode input selects addition or subtraction. The result is returned in the same sign-magnitude form, together with an overflow flag.

Inside, the block folds the mode into an effective sign for B. It converts each negative-signed operand to its nine's complement and sums the two with a ripple of decimal digit adders. The end-around carry, the result sign and the overflow are then derived from three signals: A's sign, B's effective sign and the adder carry. A negative result is converted back to a plain magnitude by a final nine's complement stage.

Two complete digit ripples run side by side, one with carry-in 0 and one with carry-in 1. The end-around carry chooses between them, so no combinational loop is formed.

Top module: `bcd_signmag_addsub`

## Requirements
- R1: B's effective sign is the exclusive-OR of `sub` and `b_sign`. Subtracting a negative B therefore gives the same result as adding a positive B of equal magnitude, and the reverse also holds.
- R2: When both effective signs are positive, `r_sign` is 0 and `r_mag` holds the decimal sum A + B.
- R3: When A's sign and B's effective sign differ, `ovf` is never asserted.
- R4: When both effective signs are negative and no overflow occurs, `r_sign` is 1 and `r_mag` holds A + B.
- R5: With opposite effective signs, `r_mag` is the magnitude of the signed difference. `r_sign` is 1 exactly when the negative-signed operand has the larger magnitude.
- R6: A zero result is always reported with `r_sign` = 0, including the case of equal magnitudes with opposite effective signs.
- R7: Digits are 8-4-2-1 coded in 4-bit fields, with digit k (weight 10^k) at bits [4k+3:4k]. For legal inputs and no overflow, every output digit lies in 0..9.
- R8: `ovf` is 1 exactly when the true signed result has a magnitude above 10^NDIG − 1. When `ovf` is 1, `r_mag` and `r_sign` carry no defined meaning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_sign | input | 1 | Sign of operand A, 1 = negative |
| a_mag | input | 4*NDIG | BCD magnitude of A |
| b_sign | input | 1 | Sign of operand B, 1 = negative |
| b_mag | input | 4*NDIG | BCD magnitude of B |
| sub | input | 1 | 1 = compute A − B, 0 = compute A + B |
| r_sign | output | 1 | Sign of the result, 1 = negative |
| r_mag | output | 4*NDIG | BCD magnitude of the result |
| ovf | output | 1 | Result magnitude exceeds NDIG digits |

## Verification
The bench builds the block with the default `NDIG` = 4. With four digits, every operand and every true result fits in a plain integer, so the reference model can work in ordinary signed arithmetic. Four digits also make the boundary operands cheap to reach: 0, 9999, equal magnitudes, and sums that land exactly on 9999 or 10000. These boundary cases are driven under all four sign combinations and both modes, followed by a stretch of random legal operands.

// File: rtl/bcd_sm_pkg.sv
package bcd_sm_pkg;

    typedef logic [3:0] bcd_digit_t;

    typedef struct packed {
        logic eac;
        logic neg;
        logic ovf;
    } sm_flags_t;

    function automatic bcd_digit_t nines_of(input bcd_digit_t d);
        return 4'd9 - d;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
    import bcd_sm_pkg::*;
(
    input  bcd_digit_t a,
    input  bcd_digit_t b,
    input  logic       ci,
    output bcd_digit_t s,
    output logic       co
);
    logic [4:0] raw;
    logic [4:0] fixed;

    always_comb begin
        raw   = {1'b0, a} + {1'b0, b} + {4'b0, ci};
        fixed = raw + 5'd6;
        if (raw > 5'd9) begin
            s  = fixed[3:0];
            co = 1'b1;
        end else begin
            s  = raw[3:0];
            co = 1'b0;
        end
    end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
    import bcd_sm_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    input  logic              ci,
    output logic [4*NDIG-1:0] sum,
    output logic              co
);
    logic [NDIG:0] carry;

    assign carry[0] = ci;

    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        bcd_digit_add u_add (
            .a  (a[4*k +: 4]),
            .b  (b[4*k +: 4]),
            .ci (carry[k]),
            .s  (sum[4*k +: 4]),
            .co (carry[k+1])
        );
    end

    assign co = carry[NDIG];
endmodule

// File: rtl/bcd_comp9.sv
module bcd_comp9
    import bcd_sm_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic              en,
    input  logic [4*NDIG-1:0] din,
    output logic [4*NDIG-1:0] dout
);
    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        assign dout[4*k +: 4] = en ? nines_of(din[4*k +: 4]) : din[4*k +: 4];
    end
endmodule

// File: rtl/sm_flag_logic.sv
module sm_flag_logic
    import bcd_sm_pkg::*;
(
    input  logic      as_i,
    input  logic      bs_eff,
    input  logic      cout,
    output sm_flags_t flags
);
    always_comb begin
        flags.eac = maj3(as_i, bs_eff, cout);
        // Mixed signs: negative when there is no carry; same signs: follow A.
        flags.neg = (as_i ^ bs_eff) ? ~cout : as_i;
        flags.ovf = flags.eac ^ cout;
    end

    always_comb begin
        // R3: operands of opposite effective sign never overflow
        a_r3_mixed_no_ovf: assert (!(as_i ^ bs_eff) || !flags.ovf)
            else $error("mixed-sign overflow");
    end
endmodule

// File: rtl/bcd_signmag_addsub.sv
module bcd_signmag_addsub
    import bcd_sm_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic              a_sign,
    input  logic [4*NDIG-1:0] a_mag,
    input  logic              b_sign,
    input  logic [4*NDIG-1:0] b_mag,
    input  logic              sub,
    output logic              r_sign,
    output logic [4*NDIG-1:0] r_mag,
    output logic              ovf
);
    localparam int W = 4 * NDIG;

    logic          bs_eff;
    logic [W-1:0]  a_op, b_op;
    logic [W-1:0]  sum0, sum1, sel_sum, out_mag;
    logic          co0, co1, cout_eff;
    sm_flags_t     flags;

    assign bs_eff = sub ^ b_sign;

    bcd_comp9 #(.NDIG(NDIG)) u_comp_a (.en(a_sign), .din(a_mag), .dout(a_op));
    bcd_comp9 #(.NDIG(NDIG)) u_comp_b (.en(bs_eff), .din(b_mag), .dout(b_op));

    bcd_ripple #(.NDIG(NDIG)) u_rip0 (.a(a_op), .b(b_op), .ci(1'b0), .sum(sum0), .co(co0));
    bcd_ripple #(.NDIG(NDIG)) u_rip1 (.a(a_op), .b(b_op), .ci(1'b1), .sum(sum1), .co(co1));

    // Both negative: the end-around carry is certain, so carry-in 1 applies.
    assign cout_eff = (a_sign & bs_eff) ? co1 : co0;

    sm_flag_logic u_flags (.as_i(a_sign), .bs_eff(bs_eff), .cout(cout_eff), .flags(flags));

    assign sel_sum = flags.eac ? sum1 : sum0;

    bcd_comp9 #(.NDIG(NDIG)) u_comp_r (.en(flags.neg), .din(sel_sum), .dout(out_mag));

    assign r_mag  = out_mag;
    assign r_sign = flags.neg & (out_mag != '0);
    assign ovf    = flags.ovf;

    function automatic logic mag_legal(input logic [W-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < NDIG; k++) begin
            if (m[4*k +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    always_comb begin
        // R6: zero is never reported as negative
        a_r6_pos_zero: assert (!(r_mag == '0 && !ovf) || !r_sign)
            else $error("negative zero");
        // R2: both effective signs positive gives a positive result
        a_r2_pos_pos: assert ((a_sign | bs_eff) || ovf || !r_sign)
            else $error("positive operands gave negative sign");
        // R4: both effective signs negative gives a negative result (non-zero)
        a_r4_neg_neg: assert (!(a_sign & bs_eff) || ovf || r_mag == '0 || r_sign)
            else $error("negative operands gave positive sign");
        // R7: legal digits in, legal digits out
        a_r7_legal_digits: assert (!(mag_legal(a_mag) && mag_legal(b_mag)) || ovf || mag_legal(r_mag))
            else $error("illegal output digit");
    end
endmodule

// File: tb/bcd_signmag_addsub_tb.sv
module bcd_signmag_addsub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NDIG = 4;
    localparam int W = 4 * NDIG;
    localparam int MAXV = 9999;

    logic         clk = 1'b0;
    logic         a_sign = 1'b0, b_sign = 1'b0, sub = 1'b0;
    logic [W-1:0] a_mag = '0, b_mag = '0;
    logic         r_sign, ovf;
    logic [W-1:0] r_mag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_signmag_addsub #(.NDIG(NDIG)) u_dut (
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .sub(sub), .r_sign(r_sign), .r_mag(r_mag), .ovf(ovf)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] m;
        int x;
        x = v;
        for (int k = 0; k < NDIG; k++) begin
            m[4*k +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return m;
    endfunction

    task automatic count(input string tag, input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input string tag, input bit as_, input int am, input bit bs_, input int bm, input bit sb);
        int av, bv, res, mag;
        bit eovf;
        @(negedge clk);
        a_sign = as_; a_mag = to_bcd(am);
        b_sign = bs_; b_mag = to_bcd(bm);
        sub = sb;
        #(CLK_PERIOD/4);
        av = as_ ? -am : am;
        bv = bs_ ? -bm : bm;
        res = sb ? av - bv : av + bv;
        mag = (res < 0) ? -res : res;
        eovf = mag > MAXV;
        count(tag, ovf == eovf, "ovf", int'(ovf), int'(eovf));
        if (!eovf) begin
            count(tag, r_sign == (res < 0), "sign", int'(r_sign), int'(res < 0));
            count(tag, r_mag == to_bcd(mag), "mag(bcd hex)", int'(r_mag), int'(to_bcd(mag)));
        end
    endtask

    task automatic t_both_positive();
        apply("R2", 0, 1234, 0, 4321, 0);
        apply("R2", 0, 5, 0, 7, 0);
        apply("R7", 0, 6941, 0, 2058, 0);
        apply("R7", 0, 0, 0, 0, 0);
    endtask

    task automatic t_effective_sign();
        apply("R1", 0, 300, 1, 45, 1);
        apply("R1", 0, 300, 0, 45, 1);
        apply("R1", 1, 300, 1, 45, 1);
        apply("R1", 1, 812, 0, 812, 1);
    endtask

    task automatic t_both_negative();
        apply("R4", 1, 1234, 1, 4321, 0);
        apply("R4", 1, 9998, 1, 1, 0);
        apply("R4", 1, 0, 0, 6, 1);
    endtask

    task automatic t_mixed();
        apply("R5", 0, 100, 1, 250, 0);
        apply("R5", 0, 250, 1, 100, 0);
        apply("R5", 1, 9999, 0, 1, 0);
        apply("R5", 0, 0, 0, 9999, 1);
        apply("R3", 0, 9999, 1, 9999, 0);
        apply("R3", 1, 9999, 1, 0, 1);
    endtask

    task automatic t_zero();
        apply("R6", 0, 4567, 1, 4567, 0);
        apply("R6", 1, 4567, 0, 4567, 0);
        apply("R6", 1, 0, 1, 0, 0);
        apply("R6", 0, 9999, 0, 9999, 1);
    endtask

    task automatic t_overflow();
        apply("R8", 0, 9999, 0, 1, 0);
        apply("R8", 0, 9998, 0, 1, 0);
        apply("R8", 1, 9999, 1, 1, 0);
        apply("R8", 1, 5000, 0, 4999, 1);
        apply("R8", 1, 5000, 0, 5000, 1);
        apply("R8", 0, 9999, 1, 9999, 1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            apply("R8", 1'($urandom_range(0, 1)), int'($urandom_range(0, MAXV)),
                        1'($urandom_range(0, 1)), int'($urandom_range(0, MAXV)),
                        1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_both_positive();
        t_effective_sign();
        t_both_negative();
        t_mixed();
        t_zero();
        t_overflow();
        t_random();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule